// File: doc/BRIEF.md
# CAN Transmit Request Scheduler

This block keeps one pending-transmit flag for each message buffer of a CAN controller. It decides which buffer the transmit engine serves next. Software raises flags through a byte-wide register window. Writing a 1 to a flag requests a send, and writing a 0 leaves the flag as it is. A flag drops only when the transmit engine reports that the frame for that buffer has completed or been cancelled.

A buffer can be configured to hold its request back until a remote request frame for it has arrived. Among the eligible buffers the lowest-numbered one wins. The winner is offered to the transmit engine over a valid/ready handshake. After a grant, no further offer is made until a done or cancel report for the granted index is seen. A completion clear always beats a software set that hits the same flag in the same cycle.

Top module: `can_txreq_sched`

## Requirements
- R1: After a synchronous reset every request flag reads 0, `tx_valid` is 0 and `reg_rdata` is 0.
- R2: A register write sets each request flag whose data bit is 1 and leaves a flag unchanged where the data bit is 0.
- R3: Register address 0 maps to flags 7..0 and address 1 maps to flags 15..8 (data bit n is flag 8*addr+n). Each byte is written and read independently, and the read data appears on `reg_rdata` one cycle after the read strobe.
- R4: A pending flag whose `rwait_cfg` bit is 0 is eligible at once. One cycle after it is written, it is offered on `tx_valid`/`tx_idx` if no lower eligible buffer exists and the scheduler is idle.
- R5: A pending flag whose `rwait_cfg` bit is 1 is not offered until its `rrx_flag` bit has been 1 for at least one cycle. After that it stays eligible even if `rrx_flag` falls again.
- R6: If `rrx_flag` is already 1 when the flag is set, the request is eligible immediately even with `rwait_cfg` = 1.
- R7: When several buffers are eligible, the offered index is the lowest-numbered eligible buffer.
- R8: A request flag stays 1 while offered or granted. A one-cycle `tx_done` or `tx_cancel` with `tx_fin_idx` = n clears flag n.
- R9: When a done/cancel clear and a software set hit the same flag in the same cycle, the flag ends at 0.
- R10: A read with `reg_rmw` = 1 returns 0 on `reg_rdata`.
- R11: After `tx_valid` && `tx_ready` the scheduler makes no new offer until done or cancel arrives for the granted index. It then re-selects from the current eligible set.
- R12: While `tx_valid` is 1 and `tx_ready` is 0, `tx_idx` stays stable. A done or cancel for the offered index withdraws the offer in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_rmw | input | 1 | Read belongs to a read-modify-write access |
| reg_addr | input | 1 | Byte select: 0 = flags 7..0, 1 = flags 15..8 |
| reg_wdata | input | 8 | Write data, 1 bits set flags |
| reg_rdata | output | 8 | Registered read data |
| rwait_cfg | input | 16 | Per-buffer wait-for-remote-request enable |
| rrx_flag | input | 16 | Per-buffer remote request received flag |
| tx_valid | output | 1 | Offer of a buffer to the transmit engine |
| tx_idx | output | 4 | Offered or granted buffer index |
| tx_ready | input | 1 | Transmit engine accepts the offer |
| tx_done | input | 1 | Transmission of `tx_fin_idx` completed |
| tx_cancel | input | 1 | Transmission of `tx_fin_idx` cancelled |
| tx_fin_idx | input | 4 | Buffer index of the done/cancel report |

## Verification
Several properties are checked on every cycle. A flag cleared by done/cancel is 0 afterwards even under a concurrent write. A zero write leaves the flags untouched, and a read-modify-write read returns zero. The offer holds steady until it is accepted, no offer appears while a grant is outstanding, an offered or granted index is always pending, and a fresh offer is the lowest eligible buffer. The bench scenarios show the rest: the byte-lane mapping, the remote-wait gating and its latching after a short remote-request pulse, the bypass when the remote request is already present, and re-selection once a grant finishes.

// File: rtl/txsched_pkg.sv
package txsched_pkg;
  typedef enum logic [1:0] {
    SEL_IDLE  = 2'd0,
    SEL_OFFER = 2'd1,
    SEL_BUSY  = 2'd2
  } sel_state_e;
endpackage

// File: rtl/txsched_req_bank.sv
module txsched_req_bank #(
  parameter int NUM_BUF = 16,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               rd_rmw,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic [NUM_BUF-1:0] rwait,
  input  logic [NUM_BUF-1:0] rrx,
  input  logic [NUM_BUF-1:0] clr_mask,
  output logic [NUM_BUF-1:0] pend,
  output logic [NUM_BUF-1:0] elig,
  output logic [BYTE_W-1:0]  rdata
);
  localparam int NUM_LANES = NUM_BUF / BYTE_W;

  logic [NUM_BUF-1:0] set_mask;
  logic [NUM_BUF-1:0] pend_next;
  logic [NUM_BUF-1:0] armed;
  logic [BYTE_W-1:0]  lane_val;

  // one write lane per byte of flags
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign set_mask[l*BYTE_W +: BYTE_W] =
      (wr_en && addr == ADDR_W'(l)) ? wdata : '0;
  end

  // completion/cancel clear dominates a same-cycle set
  assign pend_next = (pend | set_mask) & ~clr_mask;

  // a flag is eligible when not gated, or when its remote request is seen now or was seen while pending
  assign elig = pend & ~clr_mask & (~rwait | armed | rrx);

  always_comb begin
    lane_val = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (addr == ADDR_W'(l)) lane_val = pend[l*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      armed <= '0;
      rdata <= '0;
    end else begin
      pend  <= pend_next;
      armed <= (armed | rrx) & pend_next;
      if (rd_en) rdata <= rd_rmw ? '0 : lane_val;
    end
  end

  assert_zero_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata == '0 && clr_mask == '0) |=> pend == $past(pend));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_mask != '0) |=> (pend & $past(clr_mask)) == '0);

  assert_rmw_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_rmw) |=> rdata == '0);
endmodule

// File: rtl/txsched_prio_enc.sv
module txsched_prio_enc #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [N-1:0] first;

  // bit i wins only when no lower bit requests
  for (genvar i = 0; i < N; i++) begin : g_first
    if (i == 0) begin : g_base
      assign first[i] = req[i];
    end else begin : g_chain
      assign first[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (first[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/txsched_grant_fsm.sv
module txsched_grant_fsm
  import txsched_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_any,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             tx_ready,
  input  logic             fin_vld,
  input  logic [IDX_W-1:0] fin_idx,
  output logic             tx_valid,
  output logic [IDX_W-1:0] tx_idx,
  output logic             busy
);
  sel_state_e state;
  logic       fin_hit;

  assign fin_hit = fin_vld && (fin_idx == tx_idx);
  assign busy    = (state == SEL_BUSY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEL_IDLE;
      tx_valid <= 1'b0;
      tx_idx   <= '0;
    end else begin
      unique case (state)
        SEL_IDLE: if (sel_any) begin
          state    <= SEL_OFFER;
          tx_valid <= 1'b1;
          tx_idx   <= sel_idx;
        end
        SEL_OFFER: if (fin_hit) begin
          state    <= SEL_IDLE;
          tx_valid <= 1'b0;
        end else if (tx_ready) begin
          state    <= SEL_BUSY;
          tx_valid <= 1'b0;
        end
        SEL_BUSY: if (fin_hit) state <= SEL_IDLE;
        default: begin
          state    <= SEL_IDLE;
          tx_valid <= 1'b0;
        end
      endcase
    end
  end

  assert_no_offer_busy_R11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !tx_valid);

  assert_busy_until_fin_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin_hit) |=> busy && $stable(tx_idx));

  assert_offer_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !fin_hit) |=> tx_valid && $stable(tx_idx));
endmodule

// File: rtl/can_txreq_sched.sv
module can_txreq_sched #(
  parameter int NUM_BUF = 16,
  parameter int BYTE_W  = 8,
  parameter int IDX_W   = $clog2(NUM_BUF),
  parameter int ADDR_W  = (NUM_BUF / BYTE_W > 1) ? $clog2(NUM_BUF / BYTE_W) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic               reg_rmw,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [BYTE_W-1:0]  reg_wdata,
  output logic [BYTE_W-1:0]  reg_rdata,
  input  logic [NUM_BUF-1:0] rwait_cfg,
  input  logic [NUM_BUF-1:0] rrx_flag,
  output logic               tx_valid,
  output logic [IDX_W-1:0]   tx_idx,
  input  logic               tx_ready,
  input  logic               tx_done,
  input  logic               tx_cancel,
  input  logic [IDX_W-1:0]   tx_fin_idx
);
  logic [NUM_BUF-1:0] pend;
  logic [NUM_BUF-1:0] elig;
  logic [NUM_BUF-1:0] clr_mask;
  logic               fin_vld;
  logic               sel_any;
  logic [IDX_W-1:0]   sel_idx;
  logic               busy;

  assign fin_vld  = tx_done | tx_cancel;
  assign clr_mask = fin_vld ? (NUM_BUF'(1) << tx_fin_idx) : '0;

  txsched_req_bank #(
    .NUM_BUF(NUM_BUF), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
  ) bank_i (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr), .rd_en(reg_rd), .rd_rmw(reg_rmw),
    .addr(reg_addr), .wdata(reg_wdata),
    .rwait(rwait_cfg), .rrx(rrx_flag), .clr_mask(clr_mask),
    .pend(pend), .elig(elig), .rdata(reg_rdata)
  );

  txsched_prio_enc #(.N(NUM_BUF), .IDX_W(IDX_W)) prio_i (
    .req(elig), .any(sel_any), .idx(sel_idx)
  );

  txsched_grant_fsm #(.IDX_W(IDX_W)) fsm_i (
    .clk(clk), .rst(rst),
    .sel_any(sel_any), .sel_idx(sel_idx),
    .tx_ready(tx_ready), .fin_vld(fin_vld), .fin_idx(tx_fin_idx),
    .tx_valid(tx_valid), .tx_idx(tx_idx), .busy(busy)
  );

  // an offered or granted index always has its flag pending
  assert_offer_pending_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid || busy) |-> ((pend >> tx_idx) & NUM_BUF'(1)) != '0);

  // a fresh offer from idle picks the lowest buffer eligible at that edge
  assert_lowest_first_R7: assert property (@(posedge clk) disable iff (rst)
    (!tx_valid && !busy && elig != '0) |=>
      tx_valid &&
      (($past(elig) >> tx_idx) & NUM_BUF'(1)) != '0 &&
      ($past(elig) & ((NUM_BUF'(1) << tx_idx) - NUM_BUF'(1))) == '0);
endmodule

// File: tb/can_txreq_sched_tb_top.sv
`timescale 1ns/1ps
module can_txreq_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_rmw = 1'b0;
  logic [0:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] rwait_cfg = '0, rrx_flag = '0;
  logic        tx_valid;
  logic [3:0]  tx_idx;
  logic        tx_ready = 1'b0, tx_done = 1'b0, tx_cancel = 1'b0;
  logic [3:0]  tx_fin_idx = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  can_txreq_sched dut_i (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rmw(reg_rmw),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rwait_cfg(rwait_cfg), .rrx_flag(rrx_flag),
    .tx_valid(tx_valid), .tx_idx(tx_idx), .tx_ready(tx_ready),
    .tx_done(tx_done), .tx_cancel(tx_cancel), .tx_fin_idx(tx_fin_idx)
  );

  // vector fields: set[52:37] rwait[36:21] rrx[20:5] exp_valid[4] exp_idx[3:0]
  localparam int NV = 8;
  localparam logic [52:0] VEC [NV] = '{
    {16'h0001, 16'h0000, 16'h0000, 1'b1, 4'd0},
    {16'h8000, 16'h0000, 16'h0000, 1'b1, 4'd15},
    {16'h0A50, 16'h0000, 16'h0000, 1'b1, 4'd4},
    {16'h0003, 16'h0001, 16'h0000, 1'b1, 4'd1},
    {16'h0100, 16'h0100, 16'h0000, 1'b0, 4'd0},
    {16'h0100, 16'h0100, 16'h0100, 1'b1, 4'd8},
    {16'h00F0, 16'h00F0, 16'h0040, 1'b1, 4'd6},
    {16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic rmw, output logic [7:0] d);
    reg_addr = a; reg_rmw = rmw; reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0; reg_rmw = 1'b0;
    d = reg_rdata;
  endtask

  task automatic fin(input logic is_cancel, input logic [3:0] idx);
    tx_fin_idx = idx;
    if (is_cancel) tx_cancel = 1'b1; else tx_done = 1'b1;
    tick();
    tx_cancel = 1'b0; tx_done = 1'b0;
  endtask

  task automatic cancel_all();
    for (int i = 0; i < 16; i++) fin(1'b1, 4'(i));
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // reset state
    check("R1 valid", {31'd0, tx_valid}, 32'd0);
    rd(1'b0, 1'b0, d); check("R1 low byte", {24'd0, d}, 32'h00);
    rd(1'b1, 1'b0, d); check("R1 high byte", {24'd0, d}, 32'h00);

    // register access with every buffer gated
    rwait_cfg = 16'hFFFF; rrx_flag = '0;
    wr(1'b0, 8'h35);
    rd(1'b0, 1'b0, d); check("R2 set low", {24'd0, d}, 32'h35);
    rd(1'b1, 1'b0, d); check("R3 high untouched", {24'd0, d}, 32'h00);
    wr(1'b0, 8'h00);
    rd(1'b0, 1'b0, d); check("R2 zero write ignored", {24'd0, d}, 32'h35);
    wr(1'b1, 8'h81);
    rd(1'b1, 1'b0, d); check("R3 high lane", {24'd0, d}, 32'h81);
    rd(1'b0, 1'b0, d); check("R3 low kept", {24'd0, d}, 32'h35);
    rd(1'b0, 1'b1, d); check("R10 rmw read", {24'd0, d}, 32'h00);
    check("R5 all gated no offer", {31'd0, tx_valid}, 32'd0);
    cancel_all();
    rd(1'b0, 1'b0, d); check("R8 cancel low", {24'd0, d}, 32'h00);
    rd(1'b1, 1'b0, d); check("R8 cancel high", {24'd0, d}, 32'h00);

    // selection table: R4 ungated, R5 gated, R6 remote already seen, R7 lowest first
    for (int v = 0; v < NV; v++) begin
      rwait_cfg = VEC[v][36:21];
      rrx_flag  = VEC[v][20:5];
      wr(1'b0, VEC[v][44:37]);
      wr(1'b1, VEC[v][52:45]);
      tick();
      check($sformatf("R4 R5 R6 R7 vec%0d valid", v), {31'd0, tx_valid}, {31'd0, VEC[v][4]});
      if (VEC[v][4])
        check($sformatf("R7 vec%0d idx", v), {28'd0, tx_idx}, {28'd0, VEC[v][3:0]});
      cancel_all();
    end
    rwait_cfg = '0; rrx_flag = '0;
    tick();

    // grant outstanding, remote-request pulse latched meanwhile
    rwait_cfg = 16'h0004;
    wr(1'b0, 8'h01);
    tick();
    check("R4 offer idx0", {27'd0, tx_valid, tx_idx}, {27'd0, 1'b1, 4'd0});
    tx_ready = 1'b1; tick(); tx_ready = 1'b0;
    check("R11 no offer after grant", {31'd0, tx_valid}, 32'd0);
    wr(1'b0, 8'h04);
    rrx_flag = 16'h0004; tick(); rrx_flag = '0;
    tick();
    check("R11 still busy", {31'd0, tx_valid}, 32'd0);
    rd(1'b0, 1'b0, d); check("R8 pending while granted", {24'd0, d}, 32'h05);
    fin(1'b0, 4'd0);
    tick();
    check("R5 latched remote, R11 reselect", {27'd0, tx_valid, tx_idx}, {27'd0, 1'b1, 4'd2});

    // offer stability and withdrawal
    wr(1'b0, 8'h02);
    check("R12 idx stable", {27'd0, tx_valid, tx_idx}, {27'd0, 1'b1, 4'd2});
    tick();
    check("R12 idx stable again", {27'd0, tx_valid, tx_idx}, {27'd0, 1'b1, 4'd2});
    fin(1'b1, 4'd2);
    check("R12 offer withdrawn", {31'd0, tx_valid}, 32'd0);
    tick();
    check("R7 next lowest", {27'd0, tx_valid, tx_idx}, {27'd0, 1'b1, 4'd1});

    // clear beats concurrent set
    tx_ready = 1'b1; tick(); tx_ready = 1'b0;
    reg_addr = 1'b0; reg_wdata = 8'h02; reg_wr = 1'b1;
    tx_done = 1'b1; tx_fin_idx = 4'd1;
    tick();
    reg_wr = 1'b0; tx_done = 1'b0;
    rd(1'b0, 1'b0, d); check("R9 clear wins", {24'd0, d}, 32'h00);
    tick();
    check("R8 nothing left", {31'd0, tx_valid}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule